// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a combined parallel flash and EEPROM controller. It watches bus write cycles, each with an address, a data byte and a bank select. From that stream it picks out unlock-prefixed command sequences. A recognised sequence ends in a one-cycle strobe on the output that belongs to that command, and the controller behind the block acts on that strobe. The program command also latches the write that follows the command byte and presents its address and data with the strobe.

A write to the EEPROM bank that is not part of a sequence, or that breaks one, is passed through as an ordinary single-byte write strobe. A broken sequence on the flash bank is dropped without any output. Each erase command has to be confirmed by a second unlock pair and then a confirm byte. The decoder abandons a sequence when the gap between two sequence writes is too long. After reset, EEPROM pass-through writes stay blocked for a power-up window set in milliseconds. While a low-supply lockout input is high, no new sequence and no plain write can start.

An identifier mode returns fixed identifier bytes. The value depends on three address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a write of AAh to address 5555h, then 55h to 2AAAh, then A0h, the next selected write raises prog_o for exactly one cycle, one cycle after that write. prog_addr_o and prog_data_o then carry that write's address and data.
- R2: After the unlock pair, the command bytes B0h, 30h, 90h and F0h each raise only their own strobe for one cycle, one cycle after the command write: suspend_o, resume_o, read_id_o and reset_o.
- R3: After the unlock pair, command byte 80h has to be followed by a second AAh@5555h / 55h@2AAAh pair and then a confirm byte. Confirm 30h raises sect_erase_o and confirm 10h raises blk_erase_o. No strobe is raised by any write before the confirm byte.
- R4: The unlock matching compares only address bits [14:0]. Higher address bits have no effect on it.
- R5: A write that does not fit the expected step, sent to the flash bank, returns the decoder to its read state. It produces no command strobe and no plain write. A later write continues from the read state.
- R6: A write that does not fit the expected step, sent to the EEPROM bank, returns the decoder to its read state. The same write comes out as plain_wr_o, with its address and data, one cycle later.
- R7: If more than TIMEOUT_CYC clock cycles pass between two consecutive writes of a sequence, the sequence is dropped, and the later write is handled as if the decoder were in its read state. A gap of exactly TIMEOUT_CYC cycles still continues the sequence.
- R8: In the read state, an EEPROM write that is not AAh@5555h produces plain_wr_o for one cycle, one cycle later, with its address and data. A flash write in the read state that is not AAh@5555h produces nothing.
- R9: For the first CLK_KHZ*INHIBIT_MS cycles after reset is released, no plain_wr_o is produced.
- R10: While lockout_i is high, writes that arrive in the read state are ignored. They start no sequence and produce no plain write.
- R11: A write with neither bank selected (standby) changes nothing and produces no output. It also does not restart the inter-byte gap count.
- R12: With id_mode_i high and address bits 6 and 1 low, id_valid_o is 1 and id_data_o is 20h when bit 0 is 0, or E3h when bit 0 is 1. In every other case id_valid_o is 0.
- R13: After reset, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write cycle, one clock per write |
| flash_sel_i | input | 1 | Flash bank selected (has priority) |
| eep_sel_i | input | 1 | EEPROM bank selected |
| addr_i | input | ADDR_W | Write or read address |
| data_i | input | 8 | Write data |
| lockout_i | input | 1 | Low-supply lockout |
| id_mode_i | input | 1 | Identifier read mode |
| id_data_o | output | 8 | Identifier byte |
| id_valid_o | output | 1 | Identifier byte is valid |
| prog_o | output | 1 | Program strobe |
| prog_addr_o | output | ADDR_W | Latched program address |
| prog_data_o | output | 8 | Latched program data |
| sect_erase_o | output | 1 | Sector erase strobe |
| blk_erase_o | output | 1 | Block erase strobe |
| suspend_o | output | 1 | Erase suspend strobe |
| resume_o | output | 1 | Erase resume strobe |
| read_id_o | output | 1 | Read-identifier command strobe |
| reset_o | output | 1 | Reset-and-return strobe |
| plain_wr_o | output | 1 | Pass-through single EEPROM write |
| plain_addr_o | output | ADDR_W | Pass-through write address |
| plain_data_o | output | 8 | Pass-through write data |

## Verification
A wrong sequence state inside the decoder shows up at the ports no later than the end of the next sequence. It appears either as a missing or misplaced strobe one cycle after a command or confirm write, or as a plain write on the EEPROM bank where none should appear. A gap count that runs too long, or one that a standby write restarts, changes whether a prog_o strobe appears after a stretched sequence. The stretched sequences are built with gaps of exactly the limit and one cycle past it, so that count errors of one cycle are caught. Errors in the power-up window or the lockout show up as a spurious plain_wr_o in the cycle after the write that was blocked.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MATCH_W = 15;

  localparam logic [MATCH_W-1:0] UNL_A_ADDR = 15'h5555;
  localparam logic [MATCH_W-1:0] UNL_B_ADDR = 15'h2AAA;
  localparam logic [BYTE_W-1:0]  UNL_A_DATA = 8'hAA;
  localparam logic [BYTE_W-1:0]  UNL_B_DATA = 8'h55;

  localparam logic [BYTE_W-1:0] OP_PROG    = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_ERASE   = 8'h80;
  localparam logic [BYTE_W-1:0] OP_SUSPEND = 8'hB0;
  localparam logic [BYTE_W-1:0] OP_RESUME  = 8'h30;
  localparam logic [BYTE_W-1:0] OP_READID  = 8'h90;
  localparam logic [BYTE_W-1:0] OP_RESET   = 8'hF0;
  localparam logic [BYTE_W-1:0] CF_SECTOR  = 8'h30;
  localparam logic [BYTE_W-1:0] CF_BLOCK   = 8'h10;

  localparam logic [BYTE_W-1:0] ID_MFR   = 8'h20;
  localparam logic [BYTE_W-1:0] ID_FLASH = 8'hE3;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL_B,
    ST_OPCODE,
    ST_PROG_DATA,
    ST_ERS_A,
    ST_ERS_B,
    ST_ERS_CONF
  } seq_state_e;

  typedef struct packed {
    logic prog;
    logic sect_erase;
    logic blk_erase;
    logic suspend;
    logic resume;
    logic read_id;
    logic reset;
  } cmd_strb_t;
endpackage

// File: rtl/fcd_gap_timer.sv
module fcd_gap_timer #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic clear_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i || !active_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)       cnt_q <= cnt_q + CW'(1);
  end

  // saturated count marks a gap longer than the limit
  assign expire_o = active_i && (cnt_q == LIMIT);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  p_clear_restarts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !expire_o);
endmodule

// File: rtl/fcd_pwrup_inhibit.sv
module fcd_pwrup_inhibit #(
  parameter int unsigned CLK_KHZ    = 50000,
  parameter int unsigned INHIBIT_MS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic inhibit_o
);
  localparam int unsigned INHIBIT_CYC = CLK_KHZ * INHIBIT_MS;
  localparam int unsigned CW = $clog2(INHIBIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INHIBIT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign inhibit_o = (cnt_q != LIMIT);

  p_inhibit_ends_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_o |=> !inhibit_o);
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom
  import fcd_pkg::*;
(
  input  logic              id_mode_i,
  input  logic              a0_i,
  input  logic              a1_i,
  input  logic              a6_i,
  output logic [BYTE_W-1:0] id_data_o,
  output logic              id_valid_o
);
  always_comb begin
    id_valid_o = id_mode_i && !a1_i && !a6_i;
    id_data_o  = '0;
    if (id_valid_o) id_data_o = a0_i ? ID_FLASH : ID_MFR;
  end

  always_comb begin
    if (id_valid_o) p_id_mode_r12: assert (id_mode_i && id_data_o != '0);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              is_eep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              lockout_i,
  input  logic              inhibit_i,
  input  logic              expire_i,
  output logic              busy_o,
  output logic              accept_o,
  output cmd_strb_t         cmd_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [BYTE_W-1:0] prog_data_o,
  output logic              plain_wr_o,
  output logic [ADDR_W-1:0] plain_addr_o,
  output logic [BYTE_W-1:0] plain_data_o
);
  seq_state_e state_q, cur, nxt;
  cmd_strb_t  cmd_d, cmd_q;
  logic       bad, acc, plain_req, plain_d;
  logic       hit_a, hit_b;
  logic [ADDR_W-1:0] prog_addr_q, plain_addr_q;
  logic [BYTE_W-1:0] prog_data_q, plain_data_q;
  logic              plain_wr_q;

  assign hit_a = (addr_i[MATCH_W-1:0] == UNL_A_ADDR) && (data_i == UNL_A_DATA);
  assign hit_b = (addr_i[MATCH_W-1:0] == UNL_B_ADDR) && (data_i == UNL_B_DATA);

  // an expired gap makes the current write see the read state
  assign cur = expire_i ? ST_READ : state_q;

  always_comb begin
    nxt       = cur;
    cmd_d     = '0;
    bad       = 1'b0;
    acc       = 1'b0;
    plain_req = 1'b0;
    if (wr_i) begin
      unique case (cur)
        ST_READ: begin
          if (!lockout_i) begin
            if (hit_a) begin
              nxt = ST_UNL_B;
              acc = 1'b1;
            end else begin
              plain_req = is_eep_i;
            end
          end
        end
        ST_UNL_B: begin
          if (hit_b) begin
            nxt = ST_OPCODE;
            acc = 1'b1;
          end else bad = 1'b1;
        end
        ST_OPCODE: begin
          nxt = ST_READ;
          unique case (data_i)
            OP_PROG:    begin nxt = ST_PROG_DATA; acc = 1'b1; end
            OP_ERASE:   begin nxt = ST_ERS_A;     acc = 1'b1; end
            OP_SUSPEND: cmd_d.suspend = 1'b1;
            OP_RESUME:  cmd_d.resume  = 1'b1;
            OP_READID:  cmd_d.read_id = 1'b1;
            OP_RESET:   cmd_d.reset   = 1'b1;
            default:    bad = 1'b1;
          endcase
        end
        ST_PROG_DATA: begin
          cmd_d.prog = 1'b1;
          nxt        = ST_READ;
        end
        ST_ERS_A: begin
          if (hit_a) begin
            nxt = ST_ERS_B;
            acc = 1'b1;
          end else bad = 1'b1;
        end
        ST_ERS_B: begin
          if (hit_b) begin
            nxt = ST_ERS_CONF;
            acc = 1'b1;
          end else bad = 1'b1;
        end
        ST_ERS_CONF: begin
          nxt = ST_READ;
          if (data_i == CF_SECTOR)     cmd_d.sect_erase = 1'b1;
          else if (data_i == CF_BLOCK) cmd_d.blk_erase  = 1'b1;
          else                         bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
      if (bad) begin
        nxt       = ST_READ;
        plain_req = is_eep_i;
      end
    end
    plain_d = plain_req && !inhibit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_READ;
      cmd_q        <= '0;
      plain_wr_q   <= 1'b0;
      prog_addr_q  <= '0;
      prog_data_q  <= '0;
      plain_addr_q <= '0;
      plain_data_q <= '0;
    end else begin
      state_q    <= nxt;
      cmd_q      <= cmd_d;
      plain_wr_q <= plain_d;
      if (cmd_d.prog) begin
        prog_addr_q <= addr_i;
        prog_data_q <= data_i;
      end
      if (plain_d) begin
        plain_addr_q <= addr_i;
        plain_data_q <= data_i;
      end
    end
  end

  assign busy_o       = (state_q != ST_READ);
  assign accept_o     = acc;
  assign cmd_o        = cmd_q;
  assign prog_addr_o  = prog_addr_q;
  assign prog_data_o  = prog_data_q;
  assign plain_wr_o   = plain_wr_q;
  assign plain_addr_o = plain_addr_q;
  assign plain_data_o = plain_data_q;

  p_cmd_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_q));

  p_prog_after_seq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.prog |-> $past(state_q) == ST_PROG_DATA);

  p_erase_after_conf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q.sect_erase || cmd_q.blk_erase) |-> $past(state_q) == ST_ERS_CONF);

  p_expire_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !wr_i) |=> (state_q == ST_READ && cmd_q == '0 && !plain_wr_q));

  p_inhibit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !plain_wr_o);

  p_lockout_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lockout_i && cur == ST_READ) |=> (state_q == ST_READ && !plain_wr_o));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned CLK_KHZ     = 50000,
  parameter int unsigned INHIBIT_MS  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              flash_sel_i,
  input  logic              eep_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              lockout_i,
  input  logic              id_mode_i,
  output logic [7:0]        id_data_o,
  output logic              id_valid_o,
  output logic              prog_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              sect_erase_o,
  output logic              blk_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              read_id_o,
  output logic              reset_o,
  output logic              plain_wr_o,
  output logic [ADDR_W-1:0] plain_addr_o,
  output logic [7:0]        plain_data_o
);
  logic      wr_sel, is_eep, busy, accept, expire, inhibit;
  cmd_strb_t cmd;

  // standby: no bank selected, write is dropped
  assign wr_sel = wr_i && (flash_sel_i || eep_sel_i);
  assign is_eep = eep_sel_i && !flash_sel_i;

  fcd_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (busy),
    .clear_i  (accept),
    .expire_o (expire)
  );

  fcd_pwrup_inhibit #(.CLK_KHZ(CLK_KHZ), .INHIBIT_MS(INHIBIT_MS)) u_inh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inhibit_o (inhibit)
  );

  fcd_id_rom u_id (
    .id_mode_i  (id_mode_i),
    .a0_i       (addr_i[0]),
    .a1_i       (addr_i[1]),
    .a6_i       (addr_i[6]),
    .id_data_o  (id_data_o),
    .id_valid_o (id_valid_o)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_sel),
    .is_eep_i     (is_eep),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .lockout_i    (lockout_i),
    .inhibit_i    (inhibit),
    .expire_i     (expire),
    .busy_o       (busy),
    .accept_o     (accept),
    .cmd_o        (cmd),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .plain_wr_o   (plain_wr_o),
    .plain_addr_o (plain_addr_o),
    .plain_data_o (plain_data_o)
  );

  assign prog_o       = cmd.prog;
  assign sect_erase_o = cmd.sect_erase;
  assign blk_erase_o  = cmd.blk_erase;
  assign suspend_o    = cmd.suspend;
  assign resume_o     = cmd.resume;
  assign read_id_o    = cmd.read_id;
  assign reset_o      = cmd.reset;

  p_standby_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flash_sel_i && !eep_sel_i) |=>
      !(plain_wr_o || prog_o || sect_erase_o || blk_erase_o ||
        suspend_o || resume_o || read_id_o || reset_o));

  p_single_prog_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |=> !prog_o);
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int TMO = 8;

  localparam logic [1:0] FL = 2'b10;
  localparam logic [1:0] EE = 2'b01;
  localparam logic [1:0] SB = 2'b00;

  // expected strobe codes
  localparam logic [3:0] N  = 4'd0, P  = 4'd1, SE = 4'd2, BE = 4'd3, SU = 4'd4;
  localparam logic [3:0] RE = 4'd5, RI = 4'd6, RS = 4'd7, PW = 4'd8;

  localparam int NV = 50;
  // {sel[1:0], addr[18:0], data[7:0], exp[3:0], req[3:0]}
  localparam logic [36:0] VEC [NV] = '{
    // R1 program
    {FL,19'h05555,8'hAA,N,4'd1}, {FL,19'h02AAA,8'h55,N,4'd1},
    {FL,19'h05555,8'hA0,N,4'd1}, {FL,19'h01234,8'h3C,P,4'd1},
    // R2 single commands
    {FL,19'h05555,8'hAA,N,4'd2}, {FL,19'h02AAA,8'h55,N,4'd2}, {FL,19'h05555,8'hB0,SU,4'd2},
    {FL,19'h05555,8'hAA,N,4'd2}, {FL,19'h02AAA,8'h55,N,4'd2}, {FL,19'h05555,8'h30,RE,4'd2},
    {FL,19'h05555,8'hAA,N,4'd2}, {FL,19'h02AAA,8'h55,N,4'd2}, {FL,19'h05555,8'h90,RI,4'd2},
    {FL,19'h05555,8'hAA,N,4'd2}, {FL,19'h02AAA,8'h55,N,4'd2}, {FL,19'h05555,8'hF0,RS,4'd2},
    // R3 sector erase
    {FL,19'h05555,8'hAA,N,4'd3}, {FL,19'h02AAA,8'h55,N,4'd3}, {FL,19'h05555,8'h80,N,4'd3},
    {FL,19'h05555,8'hAA,N,4'd3}, {FL,19'h02AAA,8'h55,N,4'd3}, {FL,19'h07000,8'h30,SE,4'd3},
    // R3 block erase
    {FL,19'h05555,8'hAA,N,4'd3}, {FL,19'h02AAA,8'h55,N,4'd3}, {FL,19'h05555,8'h80,N,4'd3},
    {FL,19'h05555,8'hAA,N,4'd3}, {FL,19'h02AAA,8'h55,N,4'd3}, {FL,19'h05555,8'h10,BE,4'd3},
    // R5 bad confirm on flash
    {FL,19'h05555,8'hAA,N,4'd5}, {FL,19'h02AAA,8'h55,N,4'd5}, {FL,19'h05555,8'h80,N,4'd5},
    {FL,19'h05555,8'hAA,N,4'd5}, {FL,19'h02AAA,8'h55,N,4'd5}, {FL,19'h05555,8'h77,N,4'd5},
    // R4 upper address bits ignored
    {FL,19'h7D555,8'hAA,N,4'd4}, {FL,19'h42AAA,8'h55,N,4'd4},
    {FL,19'h7D555,8'hA0,N,4'd4}, {FL,19'h40ABC,8'h99,P,4'd4},
    // R5 bad second unlock on flash, then leftovers ignored
    {FL,19'h05555,8'hAA,N,4'd5}, {FL,19'h02AAA,8'h54,N,4'd5}, {FL,19'h02AAA,8'h55,N,4'd5},
    {FL,19'h05555,8'hA0,N,4'd5}, {FL,19'h00011,8'h22,N,4'd5},
    // R6 bad bytes on EEPROM pass through
    {EE,19'h05555,8'hAA,N,4'd6}, {EE,19'h02AAA,8'h12,PW,4'd6},
    {EE,19'h05555,8'hAA,N,4'd6}, {EE,19'h02AAA,8'h55,N,4'd6}, {EE,19'h00050,8'h99,PW,4'd6},
    // R8 plain EEPROM writes
    {EE,19'h00100,8'h77,PW,4'd8}, {EE,19'h05555,8'h5A,PW,4'd8}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, fsel = 1'b0, esel = 1'b0, lockout = 1'b0, id_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [7:0]    id_data;
  logic          id_valid, prog, sect, blk, susp, res, rid, rst_cmd, plain;
  logic [AW-1:0] prog_addr, plain_addr;
  logic [7:0]    prog_data, plain_data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(AW), .TIMEOUT_CYC(TMO), .CLK_KHZ(10), .INHIBIT_MS(5)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .flash_sel_i(fsel), .eep_sel_i(esel),
    .addr_i(addr), .data_i(data), .lockout_i(lockout), .id_mode_i(id_mode),
    .id_data_o(id_data), .id_valid_o(id_valid),
    .prog_o(prog), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .sect_erase_o(sect), .blk_erase_o(blk), .suspend_o(susp), .resume_o(res),
    .read_id_o(rid), .reset_o(rst_cmd),
    .plain_wr_o(plain), .plain_addr_o(plain_addr), .plain_data_o(plain_data)
  );

  task automatic do_wr(input logic [1:0] sel, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; fsel = sel[1]; esel = sel[0]; addr = a; data = d;
    @(negedge clk);
    wr = 1'b0; fsel = 1'b0; esel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input logic [AW-1:0] ea,
                     input logic [7:0] ed, input int req);
    logic [7:0] act, expv;
    act  = {plain, rst_cmd, rid, res, susp, blk, sect, prog};
    expv = (exp == 4'd0) ? 8'h00 : (8'h01 << (exp - 4'd1));
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL R%0d strobes actual %b expected %b", req, act, expv);
    end else if (exp == P && (prog_addr !== ea || prog_data !== ed)) begin
      n_fail++;
      $display("FAIL R%0d prog actual %h/%h expected %h/%h", req, prog_addr, prog_data, ea, ed);
    end else if (exp == PW && (plain_addr !== ea || plain_data !== ed)) begin
      n_fail++;
      $display("FAIL R%0d plain actual %h/%h expected %h/%h", req, plain_addr, plain_data, ea, ed);
    end
  endtask

  task automatic chk_id(input logic ev, input logic [7:0] ed);
    #1;
    n_chk++;
    if (id_valid !== ev || (ev && id_data !== ed)) begin
      n_fail++;
      $display("FAIL R12 id actual %b/%h expected %b/%h", id_valid, id_data, ev, ed);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(N, '0, '0, 13); // R13 reset state

    // R9 EEPROM write inside the power-up window
    do_wr(EE, 19'h00010, 8'h11);
    chk(N, '0, '0, 9);
    idle(60);

    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][36:35], VEC[i][34:16], VEC[i][15:8]);
      chk(VEC[i][7:4], VEC[i][34:16], VEC[i][15:8], int'(VEC[i][3:0]));
    end

    // R7 gap of exactly the limit still continues
    do_wr(FL, 19'h05555, 8'hAA);
    do_wr(FL, 19'h02AAA, 8'h55);
    idle(TMO - 2);
    do_wr(FL, 19'h05555, 8'hA0);
    idle(TMO - 2);
    do_wr(FL, 19'h00777, 8'h5E);
    chk(P, 19'h00777, 8'h5E, 7);

    // R7 one cycle past the limit drops the sequence
    do_wr(FL, 19'h05555, 8'hAA);
    do_wr(FL, 19'h02AAA, 8'h55);
    idle(TMO - 1);
    do_wr(FL, 19'h05555, 8'hA0);
    chk(N, '0, '0, 7);
    do_wr(FL, 19'h00777, 8'h5E);
    chk(N, '0, '0, 7);

    // R7 with R6: late EEPROM write becomes plain
    do_wr(EE, 19'h05555, 8'hAA);
    idle(TMO - 1);
    do_wr(EE, 19'h00300, 8'h12);
    chk(PW, 19'h00300, 8'h12, 7);

    // R11 standby write ignored in read state
    do_wr(SB, 19'h00100, 8'h77);
    chk(N, '0, '0, 11);
    // R11 standby write does not disturb a sequence
    do_wr(FL, 19'h05555, 8'hAA);
    do_wr(SB, 19'h02AAA, 8'h55);
    chk(N, '0, '0, 11);
    do_wr(FL, 19'h02AAA, 8'h55);
    do_wr(FL, 19'h05555, 8'hA0);
    do_wr(FL, 19'h00400, 8'h44);
    chk(P, 19'h00400, 8'h44, 11);
    // R11 standby write does not restart the gap count
    do_wr(FL, 19'h05555, 8'hAA);
    idle(3);
    do_wr(SB, 19'h00000, 8'h00);
    idle(2);
    do_wr(FL, 19'h02AAA, 8'h55);
    do_wr(FL, 19'h05555, 8'hA0);
    do_wr(FL, 19'h00400, 8'h44);
    chk(N, '0, '0, 11);

    // R10 lockout blocks plain writes and sequence start
    lockout = 1'b1;
    do_wr(EE, 19'h00100, 8'h77);
    chk(N, '0, '0, 10);
    do_wr(FL, 19'h05555, 8'hAA);
    lockout = 1'b0;
    do_wr(FL, 19'h02AAA, 8'h55);
    do_wr(FL, 19'h05555, 8'hA0);
    do_wr(FL, 19'h00400, 8'h44);
    chk(N, '0, '0, 10);

    // R12 identifier reads
    @(negedge clk);
    id_mode = 1'b1; addr = 19'h00000; chk_id(1'b1, 8'h20);
    addr = 19'h00001; chk_id(1'b1, 8'hE3);
    addr = 19'h7FF81; chk_id(1'b1, 8'hE3);
    addr = 19'h00040; chk_id(1'b0, 8'h00);
    addr = 19'h00002; chk_id(1'b0, 8'h00);
    id_mode = 1'b0; addr = 19'h00000; chk_id(1'b0, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule